// File: doc/BRIEF.md
# Instruction Word and Operand Decoder

This block takes one 16-bit instruction word and splits it into an operation and two operand descriptors. Each descriptor tells the rest of the pipeline how to get the operand's value. The value may come from a general register, from a memory location (the address built from a register, the stack pointer or a following instruction word), from one of the three special registers (stack pointer, program counter, overflow/excess), or from a small constant carried inside the word itself. The block does not access memory, change the stack pointer or execute anything. It only raises flags that tell the execution stage which of those actions to take.

The word is split into three fields. The operation field is in the low bits. A 5-bit destination-side operand field follows it. A 6-bit source-side operand field is in the high bits. When the operation field is zero, the middle field names an extended one-operand operation instead, and the source-side field is its only operand. Decoding takes one registered stage. The decoder also reports how many extra instruction words the pair of operands consumes, and in which of those words each operand's value is found.

Top module: `insn_decoder`

## Requirements
- R1: The operation field is word[4:0], the destination field is word[9:5] and the source field is word[15:10]. If word[4:0] is nonzero, out_special is 0 and out_op is word[4:0]. If word[4:0] is zero, out_special is 1 and out_op is word[9:5].
- R2: out_valid is registered and follows in_valid one clock later. Every other output is loaded only on a cycle when in_valid is high, and holds its value otherwise. A synchronous active-high reset clears every output to 0.
- R3: A field value from 0x00 to 0x07 selects a register directly. The reg_used flag is 1, the reg index equals the value (0..7 in the order A, B, C, X, Y, Z, I, J), and the mem and next flags are 0. Whenever reg_used is 0, the reg index reads 0.
- R4: Values 0x08 to 0x0F mean memory at the address held in register (value & 7): reg_used=1 and mem=1. Values 0x10 to 0x17 mean memory at that register plus the next word, so next=1 as well.
- R5: Value 0x18 in the destination field means a stack push: b_push=1 and b_mem=1, with the stack pointer to be pre-decremented. In the source field it means a pop: a_pop=1 and a_mem=1, with the stack pointer to be post-incremented.
- R6: Value 0x19 is a peek at the stack top: peek=1 and mem=1. Value 0x1A is memory at the stack pointer plus the next word: sp_rel=1, mem=1 and next=1.
- R7: Values 0x1B, 0x1C and 0x1D select the stack pointer, the program counter and the excess register respectively (sel_sp, sel_pc, sel_ex). mem and next are 0 for these values.
- R8: Value 0x1E means memory at the address given by the next word: mem=1 and next=1. Value 0x1F means the next word is itself the value: next=1 and mem=0.
- R9: Source-field values 0x20 to 0x3F are inline constants. a_imm is 1 and a_imm_val is (value - 0x21) mod 65536, so 0x20 gives 0xFFFF, 0x21 gives 0 and 0x3F gives 30. a_imm_val is 0 whenever a_imm is 0.
- R10: ext_words is the number of next words the instruction consumes (0, 1 or 2). The source operand takes the first one. b_word_ofs is 1 exactly when both operands consume a next word.
- R11: For an extended operation, every destination descriptor output is 0.
- R12: out_illegal is 1 for an operation field outside {0x01..0x17, 0x1A, 0x1B, 0x1E, 0x1F}. For an extended operation, it is 1 when word[9:5] is outside {0x01, 0x08..0x0C, 0x10..0x12}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_word carries a word to decode |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded outputs are fresh |
| out_special | output | 1 | Extended one-operand operation |
| out_op | output | 5 | Operation or extended operation number |
| out_illegal | output | 1 | Unassigned operation |
| ext_words | output | 2 | Next words consumed |
| b_word_ofs | output | 1 | Destination operand uses the second next word |
| a_reg | output | 3 | Source register index |
| a_reg_used | output | 1 | Source involves a register |
| a_next | output | 1 | Source consumes a next word |
| a_mem | output | 1 | Source is in memory |
| a_pop | output | 1 | Source pops (SP post-increment) |
| a_peek | output | 1 | Source is stack top |
| a_sp_rel | output | 1 | Source at SP plus next word |
| a_sel_sp | output | 1 | Source is stack pointer |
| a_sel_pc | output | 1 | Source is program counter |
| a_sel_ex | output | 1 | Source is excess register |
| a_imm | output | 1 | Source is an inline constant |
| a_imm_val | output | 16 | Inline constant value |
| b_reg | output | 3 | Destination register index |
| b_reg_used | output | 1 | Destination involves a register |
| b_next | output | 1 | Destination consumes a next word |
| b_mem | output | 1 | Destination is in memory |
| b_push | output | 1 | Destination pushes (SP pre-decrement) |
| b_peek | output | 1 | Destination is stack top |
| b_sp_rel | output | 1 | Destination at SP plus next word |
| b_sel_sp | output | 1 | Destination is stack pointer |
| b_sel_pc | output | 1 | Destination is program counter |
| b_sel_ex | output | 1 | Destination is excess register |

## Verification
The hardest cases to reach are the ones where both operands take a next word, because the destination's word offset and the word count depend on the two fields together and on a nonzero operation field. Another is the same value 0x18 meaning a push on one side and a pop on the other. A third is the extended form, where the destination field becomes an operation number and its descriptor must go quiet. The bench drives every one of the 65536 words back to back, one per clock. This covers every pairing of field values, both fixed points of the constant bias, and every legal and illegal operation number. Each result is compared one cycle later against values the bench computes from the field ranges.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned OPC_W    = 5;
  localparam int unsigned BF_W     = 5;
  localparam int unsigned AF_W     = 6;
  localparam int unsigned REG_W    = 3;
  localparam int unsigned WCNT_W   = 2;
  localparam int unsigned LIT_BIAS = 33;

  localparam int unsigned OPC_LSB  = 0;
  localparam int unsigned BF_LSB   = OPC_LSB + OPC_W;
  localparam int unsigned AF_LSB   = BF_LSB + BF_W;

  typedef struct packed {
    logic [REG_W-1:0]  ridx;
    logic              reg_used;
    logic              next;
    logic              mem;
    logic              stk;
    logic              peek;
    logic              sp_rel;
    logic              sel_sp;
    logic              sel_pc;
    logic              sel_ex;
    logic              imm;
    logic [WORD_W-1:0] imm_val;
  } operand_t;

endpackage

// File: rtl/insn_dec_operand.sv
module insn_dec_operand
  import insn_dec_pkg::*;
#(
  parameter bit IS_SRC = 1'b1
) (
  input  logic [AF_W-1:0] code,
  output operand_t        desc
);

  localparam int unsigned GRP_W = AF_W - REG_W;

  logic [GRP_W-1:0]  grp;
  logic [REG_W-1:0]  low;
  logic [WORD_W-1:0] lit_val;
  logic              lit_ok;

  assign grp = code[AF_W-1:REG_W];
  assign low = code[REG_W-1:0];

  generate
    if (IS_SRC) begin : g_lit
      assign lit_ok  = 1'b1;
      assign lit_val = WORD_W'(code) - WORD_W'(LIT_BIAS);
    end else begin : g_nolit
      assign lit_ok  = 1'b0;
      assign lit_val = '0;
    end
  endgenerate

  always_comb begin
    desc = '0;
    case (grp)
      3'd0: begin
        desc.reg_used = 1'b1;
        desc.ridx     = low;
      end
      3'd1: begin
        desc.reg_used = 1'b1;
        desc.mem      = 1'b1;
        desc.ridx     = low;
      end
      3'd2: begin
        desc.reg_used = 1'b1;
        desc.mem      = 1'b1;
        desc.next     = 1'b1;
        desc.ridx     = low;
      end
      3'd3: begin
        case (low)
          3'd0: begin
            desc.stk = 1'b1;
            desc.mem = 1'b1;
          end
          3'd1: begin
            desc.peek = 1'b1;
            desc.mem  = 1'b1;
          end
          3'd2: begin
            desc.sp_rel = 1'b1;
            desc.mem    = 1'b1;
            desc.next   = 1'b1;
          end
          3'd3: desc.sel_sp = 1'b1;
          3'd4: desc.sel_pc = 1'b1;
          3'd5: desc.sel_ex = 1'b1;
          3'd6: begin
            desc.mem  = 1'b1;
            desc.next = 1'b1;
          end
          default: desc.next = 1'b1;
        endcase
      end
      default: begin
        desc.imm     = lit_ok;
        desc.imm_val = lit_val;
      end
    endcase
  end

endmodule

// File: rtl/insn_dec_opcode.sv
module insn_dec_opcode
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [BF_W-1:0]  sub,
  output logic             special,
  output logic [OPC_W-1:0] op,
  output logic             illegal
);

  logic basic_ok;
  logic ext_ok;

  always_comb begin
    case (opc)
      5'h18, 5'h19, 5'h1C, 5'h1D, 5'h00: basic_ok = 1'b0;
      default:                           basic_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (sub)
      5'h01,
      5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C,
      5'h10, 5'h11, 5'h12: ext_ok = 1'b1;
      default:             ext_ok = 1'b0;
    endcase
  end

  assign special = (opc == '0);
  assign op      = special ? OPC_W'(sub) : opc;
  assign illegal = special ? !ext_ok : !basic_ok;

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_special,
  output logic [OPC_W-1:0]  out_op,
  output logic              out_illegal,
  output logic [WCNT_W-1:0] ext_words,
  output logic              b_word_ofs,
  output logic [REG_W-1:0]  a_reg,
  output logic              a_reg_used,
  output logic              a_next,
  output logic              a_mem,
  output logic              a_pop,
  output logic              a_peek,
  output logic              a_sp_rel,
  output logic              a_sel_sp,
  output logic              a_sel_pc,
  output logic              a_sel_ex,
  output logic              a_imm,
  output logic [WORD_W-1:0] a_imm_val,
  output logic [REG_W-1:0]  b_reg,
  output logic              b_reg_used,
  output logic              b_next,
  output logic              b_mem,
  output logic              b_push,
  output logic              b_peek,
  output logic              b_sp_rel,
  output logic              b_sel_sp,
  output logic              b_sel_pc,
  output logic              b_sel_ex
);

  logic [OPC_W-1:0] opc_f;
  logic [BF_W-1:0]  bf_f;
  logic [AF_W-1:0]  af_f;

  assign opc_f = in_word[OPC_LSB +: OPC_W];
  assign bf_f  = in_word[BF_LSB  +: BF_W];
  assign af_f  = in_word[AF_LSB  +: AF_W];

  logic             spc_d;
  logic [OPC_W-1:0] op_d;
  logic             ill_d;
  operand_t         src_d;
  operand_t         dst_raw;
  operand_t         dst_d;
  logic [WCNT_W-1:0] cnt_d;
  logic             ofs_d;

  insn_dec_opcode opc_i (
    .opc     (opc_f),
    .sub     (bf_f),
    .special (spc_d),
    .op      (op_d),
    .illegal (ill_d)
  );

  insn_dec_operand #(.IS_SRC(1'b1)) src_i (
    .code (af_f),
    .desc (src_d)
  );

  insn_dec_operand #(.IS_SRC(1'b0)) dst_i (
    .code ({{(AF_W-BF_W){1'b0}}, bf_f}),
    .desc (dst_raw)
  );

  assign dst_d = spc_d ? '0 : dst_raw;
  assign cnt_d = WCNT_W'(src_d.next) + WCNT_W'(dst_d.next);
  assign ofs_d = src_d.next && dst_d.next;

  operand_t src_q;
  operand_t dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_special <= 1'b0;
      out_op      <= '0;
      out_illegal <= 1'b0;
      ext_words   <= '0;
      b_word_ofs  <= 1'b0;
      src_q       <= '0;
      dst_q       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_special <= spc_d;
        out_op      <= op_d;
        out_illegal <= ill_d;
        ext_words   <= cnt_d;
        b_word_ofs  <= ofs_d;
        src_q       <= src_d;
        dst_q       <= dst_d;
      end
    end
  end

  assign a_reg      = src_q.ridx;
  assign a_reg_used = src_q.reg_used;
  assign a_next     = src_q.next;
  assign a_mem      = src_q.mem;
  assign a_pop      = src_q.stk;
  assign a_peek     = src_q.peek;
  assign a_sp_rel   = src_q.sp_rel;
  assign a_sel_sp   = src_q.sel_sp;
  assign a_sel_pc   = src_q.sel_pc;
  assign a_sel_ex   = src_q.sel_ex;
  assign a_imm      = src_q.imm;
  assign a_imm_val  = src_q.imm_val;

  assign b_reg      = dst_q.ridx;
  assign b_reg_used = dst_q.reg_used;
  assign b_next     = dst_q.next;
  assign b_mem      = dst_q.mem;
  assign b_push     = dst_q.stk;
  assign b_peek     = dst_q.peek;
  assign b_sp_rel   = dst_q.sp_rel;
  assign b_sel_sp   = dst_q.sel_sp;
  assign b_sel_pc   = dst_q.sel_pc;
  assign b_sel_ex   = dst_q.sel_ex;

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk
  import insn_dec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_special,
  input logic [WCNT_W-1:0] ext_words,
  input logic              b_word_ofs,
  input logic [REG_W-1:0]  a_reg,
  input logic              a_reg_used,
  input logic              a_next,
  input logic              a_mem,
  input logic              a_pop,
  input logic              a_peek,
  input logic              a_sp_rel,
  input logic              a_sel_sp,
  input logic              a_imm,
  input logic              b_reg_used,
  input logic              b_next,
  input logic              b_mem,
  input logic              b_push,
  input logic              b_peek,
  input logic              b_sp_rel,
  input logic              b_sel_sp,
  input logic              b_sel_pc,
  input logic              b_sel_ex
);

  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_SPECIAL_SPLIT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_special == ($past(in_word[4:0]) == 5'd0))); // R1

  AST_REG_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[15:13] == 3'b000) |=>
      (a_reg_used && !a_mem && !a_next && a_reg == $past(in_word[12:10]))); // R3

  AST_REG_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[15:13] == 3'b010) |=> (a_reg_used && a_mem && a_next)); // R4

  AST_PUSH_DST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[4:0] != 5'd0 && in_word[9:5] == 5'h18) |=> (b_push && b_mem)); // R5

  AST_STACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_pop, a_peek, a_sp_rel, a_sel_sp, a_imm})); // R6

  AST_LIT_PURE: assert property (@(posedge clk) disable iff (rst)
    a_imm |-> !(a_mem || a_next || a_reg_used)); // R9

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && b_word_ofs) |-> (a_next && b_next)); // R10

  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ext_words == ({1'b0, a_next} + {1'b0, b_next}))); // R10

  AST_SPECIAL_DST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_special) |->
      !(b_reg_used || b_next || b_mem || b_push || b_peek ||
        b_sp_rel || b_sel_sp || b_sel_pc || b_sel_ex)); // R11

endmodule

bind insn_decoder insn_decoder_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_special(out_special),
  .ext_words  (ext_words),
  .b_word_ofs (b_word_ofs),
  .a_reg      (a_reg),
  .a_reg_used (a_reg_used),
  .a_next     (a_next),
  .a_mem      (a_mem),
  .a_pop      (a_pop),
  .a_peek     (a_peek),
  .a_sp_rel   (a_sp_rel),
  .a_sel_sp   (a_sel_sp),
  .a_imm      (a_imm),
  .b_reg_used (b_reg_used),
  .b_next     (b_next),
  .b_mem      (b_mem),
  .b_push     (b_push),
  .b_peek     (b_peek),
  .b_sp_rel   (b_sp_rel),
  .b_sel_sp   (b_sel_sp),
  .b_sel_pc   (b_sel_pc),
  .b_sel_ex   (b_sel_ex)
);

// File: tb/insn_decoder_tb.sv
`timescale 1ns/1ps
module insn_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;

  logic        out_valid, out_special, out_illegal, b_word_ofs;
  logic [4:0]  out_op;
  logic [1:0]  ext_words;
  logic [2:0]  a_reg, b_reg;
  logic        a_reg_used, a_next, a_mem, a_pop, a_peek, a_sp_rel;
  logic        a_sel_sp, a_sel_pc, a_sel_ex, a_imm;
  logic [15:0] a_imm_val;
  logic        b_reg_used, b_next, b_mem, b_push, b_peek, b_sp_rel;
  logic        b_sel_sp, b_sel_pc, b_sel_ex;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  insn_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_special(out_special), .out_op(out_op),
    .out_illegal(out_illegal), .ext_words(ext_words), .b_word_ofs(b_word_ofs),
    .a_reg(a_reg), .a_reg_used(a_reg_used), .a_next(a_next), .a_mem(a_mem),
    .a_pop(a_pop), .a_peek(a_peek), .a_sp_rel(a_sp_rel), .a_sel_sp(a_sel_sp),
    .a_sel_pc(a_sel_pc), .a_sel_ex(a_sel_ex), .a_imm(a_imm), .a_imm_val(a_imm_val),
    .b_reg(b_reg), .b_reg_used(b_reg_used), .b_next(b_next), .b_mem(b_mem),
    .b_push(b_push), .b_peek(b_peek), .b_sp_rel(b_sp_rel), .b_sel_sp(b_sel_sp),
    .b_sel_pc(b_sel_pc), .b_sel_ex(b_sel_ex)
  );

  // Descriptor packing: ridx(3) reg_used next mem stack peek sp_rel sp pc ex imm imm_val(16)
  function automatic logic [28:0] model(input int c, input bit src);
    logic [2:0]  ri = 3'd0;
    logic [9:0]  f  = 10'd0;
    logic [15:0] v  = 16'd0;
    if (c < 8) begin ri = 3'(c); f[9] = 1'b1; end
    else if (c < 16) begin ri = 3'(c - 8); f[9] = 1'b1; f[7] = 1'b1; end
    else if (c < 24) begin ri = 3'(c - 16); f[9] = 1'b1; f[8] = 1'b1; f[7] = 1'b1; end
    else if (c == 24) begin f[6] = 1'b1; f[7] = 1'b1; end
    else if (c == 25) begin f[5] = 1'b1; f[7] = 1'b1; end
    else if (c == 26) begin f[4] = 1'b1; f[7] = 1'b1; f[8] = 1'b1; end
    else if (c == 27) f[3] = 1'b1;
    else if (c == 28) f[2] = 1'b1;
    else if (c == 29) f[1] = 1'b1;
    else if (c == 30) begin f[7] = 1'b1; f[8] = 1'b1; end
    else if (c == 31) f[8] = 1'b1;
    else if (src) begin f[0] = 1'b1; v = 16'((c + 65536 - 33) % 65536); end
    return {ri, f, v};
  endfunction

  function automatic string tag_of(input int c);
    if (c < 8) return "R3";
    if (c < 24) return (c == 24) ? "R5" : "R4";
    if (c == 24) return "R5";
    if (c < 27) return "R6";
    if (c < 30) return "R7";
    if (c < 32) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s word=%h got=%h exp=%h", req, in_word, got, exp);
    end
  endtask

  task automatic check_word(input int w);
    int op = w & 31;
    int bf = (w >> 5) & 31;
    int af = (w >> 10) & 63;
    bit spc = (op == 0);
    bit legal;
    logic [28:0] ea, eb, ga, gb;
    logic [1:0] ecnt;
    bit eofs;
    ea = model(af, 1'b1);
    eb = spc ? 29'd0 : model(bf, 1'b0);
    ga = {a_reg, a_reg_used, a_next, a_mem, a_pop, a_peek, a_sp_rel,
          a_sel_sp, a_sel_pc, a_sel_ex, a_imm, a_imm_val};
    gb = {b_reg, b_reg_used, b_next, b_mem, b_push, b_peek, b_sp_rel,
          b_sel_sp, b_sel_pc, b_sel_ex, 1'b0, 16'h0};
    if (spc) legal = (bf == 1) || (bf >= 8 && bf <= 12) || (bf >= 16 && bf <= 18);
    else legal = (op <= 23) || op == 26 || op == 27 || op == 30 || op == 31;
    ecnt = 2'(ea[24]) + 2'(eb[24]);
    eofs = ea[24] && eb[24];
    chk(out_valid == 1'b1, "R2", 32'(out_valid), 32'd1);
    chk(out_special == spc && out_op == 5'(spc ? bf : op), "R1",
        {26'd0, out_special, out_op}, {26'd0, spc, 5'(spc ? bf : op)});
    chk(ga == ea, tag_of(af), 32'(ga), 32'(ea));
    chk(gb == eb, spc ? "R11" : tag_of(bf), 32'(gb), 32'(eb));
    chk(ext_words == ecnt && b_word_ofs == eofs, "R10",
        {29'd0, ext_words, b_word_ofs}, {29'd0, ecnt, eofs});
    chk(out_illegal == !legal, "R12", 32'(out_illegal), 32'(!legal));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R2
    chk({out_valid, out_special, out_op, out_illegal, ext_words, b_word_ofs} == '0 &&
        {a_reg, a_reg_used, a_next, a_mem, a_pop, a_imm, a_imm_val} == '0 &&
        {b_reg, b_reg_used, b_next, b_mem, b_push} == '0, "R2", 32'(out_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", 32'(out_valid), 32'd0);
    // exhaustive sweep, one word per clock
    in_valid = 1'b1;
    in_word = 16'd0;
    for (int w = 0; w < 65536; w++) begin
      in_word = 16'(w);
      @(negedge clk);
      check_word(w);
    end
    // idle: valid drops, held fields keep the last word (0xFFFF) R2
    in_valid = 1'b0;
    in_word = 16'h0421;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", 32'(out_valid), 32'd0);
    chk(out_op == 5'h1F && a_imm_val == 16'd30, "R2", {11'd0, out_op, a_imm_val}, {11'd0, 5'h1F, 16'd30});
    // synchronous reset mid-run R2
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_op == 5'd0 && a_imm == 1'b0, "R2",
        {27'd0, out_valid, out_op[2:0], a_imm}, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule